// File: doc/BRIEF.md
# Two-Wire Slave Register Port with Segmented Address Stepping

This block is the serial-bus front end of a data-capture decoder. An external controller reaches a 0x00 to 0x31 space of control, status and captured-data bytes through it. The block recognises its own 7-bit device address, keeps a word-address pointer, and turns bus traffic into single-cycle read and write strobes toward the storage and control logic beside it. The data line is driven only by pulling it low; the clock line is only sampled.

In a write transaction the first data byte sets the pointer and later bytes become register writes. A read transaction returns bytes from the current pointer. After each accepted byte the pointer steps, but only inside two fixed segments, and it parks on each segment's last address. The remaining addresses are direct: the pointer stays put.

Top module: `pdc_i2c_regif`

## Requirements
- R1: The device address is 7'h11 when `addr_sel_i` is 0 and 7'h10 when it is 1 (bit 0 of the address byte is read=1/write=0); a matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R2: After a non-matching address byte the block gives no acknowledge, leaves SDA released and issues no strobes until the next START.
- R3: In a write transaction the first data byte loads the word address and causes no strobe; every later byte pulses `wr_strobe_o` for one cycle with `wr_data_o` and `reg_addr_o` valid; every byte written is acknowledged.
- R4: At addresses 0x00, 0x01 and 0x10 the word address does not change after a byte.
- R5: Inside 0x02..0x0F the word address steps by one after each accepted byte and stays at 0x0F once there.
- R6: Inside 0x11..0x31 the word address steps by one after each accepted byte and stays at 0x31 once there.
- R7: A read returns `rd_data_i` at the word address, MSB first, with one `rd_strobe_o` pulse per byte; the pointer steps only when the controller acknowledges the byte, so after a not-acknowledge the next read starts at the same address.
- R8: Address 0x01 and any address above 0x31 read as 0x00 with no `rd_strobe_o`; bytes written to an address above 0x31 are acknowledged but raise no `wr_strobe_o`.
- R9: The block changes its SDA drive only while SCL is low.
- R10: After reset SDA is released, both strobes are low and the word address is 0x00.
- R11: A repeated START begins a fresh address phase; the word address is kept across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_sel_i | input | 1 | Picks one of the two device addresses |
| reg_addr_o | output | 8 | Current word address toward storage |
| rd_data_i | input | 8 | Byte at `reg_addr_o` from storage |
| rd_strobe_o | output | 1 | One-cycle pulse when a byte is taken for reading |
| wr_data_o | output | 8 | Byte to write |
| wr_strobe_o | output | 1 | One-cycle write pulse |

## Verification
The bench drives segment ends with bursts longer than what is left of the segment: a design that wrapped or crossed into the next region would log writes at 0x10 or 0x32 or read the wrong byte after 0x0F and 0x31. Bursts at the direct addresses catch a pointer that steps where it must hold. A read ended by not-acknowledge, followed by a second read, exposes a pointer that steps on the final byte. A foreign device address followed by data shows whether the block wrongly acknowledges or writes, and a repeated START after setting the pointer shows whether the address phase restarts cleanly without losing the pointer.

// File: rtl/pdc_i2c_pkg.sv
package pdc_i2c_pkg;

  localparam logic [7:0] SEG_A_LO = 8'h02;
  localparam logic [7:0] SEG_A_HI = 8'h0F;
  localparam logic [7:0] SEG_B_LO = 8'h11;
  localparam logic [7:0] SEG_B_HI = 8'h31;
  localparam logic [7:0] TOP_ADDR = 8'h31;
  localparam logic [7:0] WO_ADDR  = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACKA, ST_WR, ST_ACKW, ST_RD, ST_RACK, ST_SKIP
  } bus_state_t;

  // Pointer after one accepted byte: steps inside a segment, parks on its end.
  function automatic logic [7:0] step_addr(input logic [7:0] a);
    if ((a >= SEG_A_LO && a < SEG_A_HI) || (a >= SEG_B_LO && a < SEG_B_HI))
      return a + 8'd1;
    return a;
  endfunction

  function automatic logic readable(input logic [7:0] a);
    return (a <= TOP_ADDR) && (a != WO_ADDR);
  endfunction

  function automatic logic [6:0] dev_addr(input logic sel);
    return sel ? 7'h10 : 7'h11;
  endfunction

endpackage

// File: rtl/pdc_i2c_sync.sv
module pdc_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

  assert_bus_events_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));

endmodule

// File: rtl/pdc_i2c_waddr.sv
module pdc_i2c_waddr
  import pdc_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       step_i,
  output logic [7:0] wa_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wa_o <= 8'h00;
    else if (load_i) wa_o <= load_val_i;
    else if (step_i) wa_o <= step_addr(wa_o);
  end

  assert_direct_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (wa_o == 8'h00 || wa_o == 8'h01 || wa_o == 8'h10))
      |=> (wa_o == $past(wa_o)));

  assert_seg_a_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && wa_o >= SEG_A_LO && wa_o < SEG_A_HI)
      |=> (wa_o == 8'($past(wa_o) + 8'd1)));

  assert_seg_a_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && wa_o == SEG_A_HI) |=> (wa_o == SEG_A_HI));

  assert_seg_b_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && wa_o >= SEG_B_LO && wa_o < SEG_B_HI)
      |=> (wa_o == 8'($past(wa_o) + 8'd1)));

  assert_seg_b_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && wa_o == SEG_B_HI) |=> (wa_o == SEG_B_HI));

endmodule

// File: rtl/pdc_i2c_regif.sv
module pdc_i2c_regif
  import pdc_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       addr_sel_i,
  output logic [7:0] reg_addr_o,
  input  logic [7:0] rd_data_i,
  output logic       rd_strobe_o,
  output logic [7:0] wr_data_o,
  output logic       wr_strobe_o
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  bus_state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       rw_q, first_q, mack_q;
  logic [7:0] wa;

  pdc_i2c_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  // Named internal events
  logic byte_done, addr_hit, load_evt, rd_evt, wr_evt, wa_load, wa_step;
  logic [7:0] rd_byte;

  assign byte_done = (bitcnt == BYTE_BITS) & scl_fall;
  assign addr_hit  = (shreg[7:1] == dev_addr(addr_sel_i));
  assign load_evt  = scl_fall & (((state == ST_ACKA) & rw_q) | ((state == ST_RACK) & mack_q));
  assign rd_evt    = load_evt & readable(wa);
  assign rd_byte   = readable(wa) ? rd_data_i : 8'h00;
  assign wr_evt    = (state == ST_WR) & byte_done & ~first_q & (wa <= TOP_ADDR);
  assign wa_load   = (state == ST_WR) & byte_done & first_q;
  assign wa_step   = ((state == ST_WR) & byte_done & ~first_q)
                   | ((state == ST_RACK) & scl_rise & ~sda_s);

  pdc_i2c_waddr waddr_i (
    .clk(clk), .rst_n(rst_n), .load_i(wa_load), .load_val_i(shreg),
    .step_i(wa_step), .wa_o(wa)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= 4'd0;
      shreg   <= 8'h00;
      rw_q    <= 1'b0;
      first_q <= 1'b1;
      mack_q  <= 1'b0;
    end else if (bus_start) begin
      state   <= ST_ADDR;
      bitcnt  <= 4'd0;
      first_q <= 1'b1;
    end else if (bus_stop) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise && bitcnt < BYTE_BITS) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_done) begin
            if (state == ST_WR) begin
              state   <= ST_ACKW;
              first_q <= 1'b0;
            end else if (addr_hit) begin
              state <= ST_ACKA;
              rw_q  <= shreg[0];
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ACKA: if (scl_fall) begin
          bitcnt <= 4'd0;
          if (rw_q) begin
            state <= ST_RD;
            shreg <= rd_byte;
          end else begin
            state <= ST_WR;
          end
        end
        ST_ACKW: if (scl_fall) begin
          state  <= ST_WR;
          bitcnt <= 4'd0;
        end
        ST_RD: if (scl_fall) begin
          if (bitcnt == 4'd7) state <= ST_RACK;
          else begin
            shreg  <= {shreg[6:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              state  <= ST_RD;
              bitcnt <= 4'd0;
              shreg  <= rd_byte;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o  = (state == ST_ACKA) | (state == ST_ACKW) | ((state == ST_RD) & ~shreg[7]);
  assign reg_addr_o  = wa;
  assign wr_data_o   = shreg;
  assign wr_strobe_o = wr_evt;
  assign rd_strobe_o = rd_evt;

  assert_sda_steady_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe_o && wr_strobe_o));

  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!sda_pull_o && !rd_strobe_o && !wr_strobe_o));

  assert_read_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_o |-> (reg_addr_o <= TOP_ADDR && reg_addr_o != WO_ADDR));

endmodule

// File: tb/pdc_i2c_regif_tb.sv
module pdc_i2c_regif_tb_top;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_pull, rd_strobe, wr_strobe;
  logic [7:0] reg_addr, rd_data, wr_data;
  logic sda_line;
  logic [7:0] mem [0:255];

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, r9_viol = 0;
  logic [7:0] wr_a [0:31];
  logic [7:0] wr_d [0:31];
  logic prev_scl = 1'b1, prev_pull = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;
  assign rd_data  = mem[reg_addr];

  pdc_i2c_regif dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .addr_sel_i(addr_sel), .reg_addr_o(reg_addr),
    .rd_data_i(rd_data), .rd_strobe_o(rd_strobe), .wr_data_o(wr_data),
    .wr_strobe_o(wr_strobe)
  );

  always @(negedge clk) begin
    if (wr_strobe) begin
      if (wr_cnt < 32) begin wr_a[wr_cnt] = reg_addr; wr_d[wr_cnt] = wr_data; end
      wr_cnt++;
    end
    if (rd_strobe) rd_cnt++;
    if (m_scl && prev_scl && sda_pull != prev_pull) r9_viol++;
    prev_scl  = m_scl;
    prev_pull = sda_pull;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(); repeat (H) @(negedge clk); endtask
  task automatic hh(); repeat (H/2) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); m_sda = 1'b0; hw(); m_scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw(); m_scl = 1'b1; hw(); m_sda = 1'b1; hw();
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(); m_scl = 1'b1; hw(); m_scl = 1'b0;
    end
    m_sda = 1'b1; hw(); m_scl = 1'b1; hh(); ack = ~sda_line; hh(); m_scl = 1'b0;
  endtask

  task automatic rb(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); m_scl = 1'b1; hh(); b[i] = sda_line; hh(); m_scl = 1'b0;
    end
    m_sda = ~give_ack; hw(); m_scl = 1'b1; hw(); m_scl = 1'b0; m_sda = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    logic ack;
    bus_start(); wb(8'h22, ack); wb(a, ack); bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R10 sda released", sda_pull, 0);
    chk(!rd_strobe && !wr_strobe, "R10 strobes low", {rd_strobe, wr_strobe}, 0);
    chk(reg_addr == 8'h00, "R10 pointer", reg_addr, 0);
  endtask

  task automatic t_write_seg_b();
    logic ack;
    int base = wr_cnt;
    bus_start(); wb(8'h22, ack);
    chk(ack, "R1 address ack sel0", ack, 1);
    wb(8'h2F, ack);
    chk(wr_cnt == base, "R3 pointer byte no strobe", wr_cnt - base, 0);
    for (int k = 0; k < 4; k++) begin
      wb(8'hC0 + 8'(k), ack);
      chk(ack, "R3 data ack", ack, 1);
    end
    bus_stop();
    chk(wr_cnt == base + 4, "R3 write count", wr_cnt - base, 4);
    chk(wr_a[base] == 8'h2F && wr_a[base+1] == 8'h30, "R6 step", wr_a[base+1], 8'h30);
    chk(wr_a[base+2] == 8'h31 && wr_a[base+3] == 8'h31, "R6 park at 31", wr_a[base+3], 8'h31);
    chk(wr_d[base+3] == 8'hC3, "R3 write data", wr_d[base+3], 8'hC3);
  endtask

  task automatic t_write_seg_a();
    logic ack;
    int base = wr_cnt;
    bus_start(); wb(8'h22, ack); wb(8'h0E, ack);
    for (int k = 0; k < 3; k++) wb(8'h50 + 8'(k), ack);
    bus_stop();
    chk(wr_a[base] == 8'h0E && wr_a[base+1] == 8'h0F, "R5 step", wr_a[base+1], 8'h0F);
    chk(wr_a[base+2] == 8'h0F, "R5 park at 0F", wr_a[base+2], 8'h0F);
  endtask

  task automatic t_direct();
    logic ack;
    int base;
    foreach (mem[j]) if (j == 0) ;
    for (int s = 0; s < 3; s++) begin
      logic [7:0] a = (s == 0) ? 8'h00 : (s == 1) ? 8'h01 : 8'h10;
      base = wr_cnt;
      bus_start(); wb(8'h22, ack); wb(a, ack);
      wb(8'h11, ack); wb(8'h22, ack); wb(8'h33, ack);
      bus_stop();
      chk(wr_a[base] == a && wr_a[base+1] == a && wr_a[base+2] == a,
          "R4 direct hold", wr_a[base+2], a);
    end
  endtask

  task automatic t_read_seg();
    logic ack;
    logic [7:0] b;
    int rbase;
    set_ptr(8'h0D);
    rbase = rd_cnt;
    bus_start(); wb(8'h23, ack);
    chk(ack, "R1 read address ack", ack, 1);
    rb(1'b1, b); chk(b == mem[8'h0D], "R7 read byte0", b, mem[8'h0D]);
    rb(1'b1, b); chk(b == mem[8'h0E], "R7 read byte1", b, mem[8'h0E]);
    rb(1'b1, b); chk(b == mem[8'h0F], "R5 read at 0F", b, mem[8'h0F]);
    rb(1'b0, b); chk(b == mem[8'h0F], "R5 read parked", b, mem[8'h0F]);
    bus_stop();
    chk(rd_cnt == rbase + 4, "R7 read strobes", rd_cnt - rbase, 4);
  endtask

  task automatic t_nack_hold();
    logic ack;
    logic [7:0] b;
    set_ptr(8'h20);
    bus_start(); wb(8'h23, ack); rb(1'b0, b); bus_stop();
    chk(b == mem[8'h20], "R7 first read", b, mem[8'h20]);
    bus_start(); wb(8'h23, ack); rb(1'b0, b); bus_stop();
    chk(b == mem[8'h20], "R7 no step on nack", b, mem[8'h20]);
  endtask

  task automatic t_unreadable();
    logic ack;
    logic [7:0] b;
    int rbase, wbase;
    set_ptr(8'h01);
    rbase = rd_cnt;
    bus_start(); wb(8'h23, ack); rb(1'b0, b); bus_stop();
    chk(b == 8'h00, "R8 write-only reads zero", b, 0);
    chk(rd_cnt == rbase, "R8 no read strobe", rd_cnt - rbase, 0);
    wbase = wr_cnt;
    bus_start(); wb(8'h22, ack); wb(8'h40, ack); wb(8'h99, ack);
    chk(ack, "R8 above-range write acked", ack, 1);
    bus_stop();
    chk(wr_cnt == wbase, "R8 above-range write ignored", wr_cnt - wbase, 0);
    bus_start(); wb(8'h23, ack); rb(1'b0, b); bus_stop();
    chk(b == 8'h00, "R8 above-range reads zero", b, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    int wbase = wr_cnt;
    addr_sel = 1'b1;
    bus_start(); wb(8'h22, ack);
    chk(!ack, "R2 foreign address nack", ack, 0);
    wb(8'h05, ack);
    chk(!ack, "R2 foreign data nack", ack, 0);
    wb(8'h77, ack);
    bus_stop();
    chk(wr_cnt == wbase, "R2 no strobes", wr_cnt - wbase, 0);
    bus_start(); wb(8'h20, ack);
    chk(ack, "R1 address ack sel1", ack, 1);
    wb(8'h11, ack); wb(8'h5A, ack); bus_stop();
    chk(wr_cnt == wbase + 1 && wr_a[wbase] == 8'h11 && wr_d[wbase] == 8'h5A,
        "R1 write via sel1", wr_a[wbase], 8'h11);
    addr_sel = 1'b0;
  endtask

  task automatic t_rstart();
    logic ack;
    logic [7:0] b;
    bus_start(); wb(8'h22, ack); wb(8'h12, ack);
    bus_start(); wb(8'h23, ack);
    chk(ack, "R11 repeated start ack", ack, 1);
    rb(1'b0, b); bus_stop();
    chk(b == mem[8'h12], "R11 read after repeated start", b, mem[8'h12]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 7);
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_seg_b();
    t_write_seg_a();
    t_direct();
    t_read_seg();
    t_nack_hold();
    t_unreadable();
    t_mismatch();
    t_rstart();
    chk(r9_viol == 0, "R9 sda steady while scl high", r9_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule